// File: doc/BRIEF.md
# Decode-Stage Branch Resolution Unit

This block chooses the next fetch address for a five-stage RISC pipeline. It holds the IF/ID pipeline register and decodes the instruction held there. Conditional branches are resolved in decode, using a zero test on the forwarded source operand and a dedicated target adder, so a taken branch costs one fetch slot rather than three. Unconditional jumps and calls are also redirected from decode. The fetch stage supplies the instruction it has just read and that instruction's address. The block returns the address to fetch next, a redirect flag and a squash flag that empties IF/ID.

A mode input selects how the fetch slot that follows a redirect is handled. In delayed mode that slot is a delay slot: its instruction always proceeds into decode and completes. In predict-not-taken mode fetch keeps running sequentially, and the successor is discarded only when the branch or jump actually redirects. A branch whose tested register is written by the instruction in EX has to wait for the forwarded value. The block holds fetch and IF/ID for one cycle in that case, or for two cycles when the producer is a load.

Top module: `decode_redirect_unit`

## Requirements
- R1: For the first cycle after synchronous reset, the decode slot is empty: `id_wr_en` is 0 and `id_instr` is 0. `redirect`, `squash` and `stall_req` are 0, and `next_pc` is `fetch_pc + 4`.
- R2: When there is no stall and no redirect, `next_pc` equals `fetch_pc + 4`. At the next edge IF/ID captures `fetch_instr` and `fetch_pc`, and `id_wr_en` goes to 1.
- R3: Opcode bits 31:26 select the instruction. Value 6'h04 branches when the register named by bits 25:21 equals zero. Value 6'h05 branches when that register is non-zero. A branch whose condition fails does not redirect. The tested value is `rs_val`.
- R4: The target of a taken conditional branch is the branch's own address plus the sign-extended value of bits 15:0. Negative offsets move backwards.
- R5: Opcodes 6'h02 (jump) and 6'h03 (call) always redirect. The target is bits 31:28 of (branch address + 4), followed by bits 25:0, followed by two zero bits.
- R6: With `delay_mode` = 1, a redirect never raises `squash`. The instruction fetched right after the branch enters decode with `id_wr_en` = 1.
- R7: With `delay_mode` = 0, every redirect raises `squash`. In the next cycle `id_wr_en` is 0 and `id_instr` is 0. A branch that does not redirect raises no squash.
- R8: A conditional branch is stalled for one cycle when `ex_wr_en` is 1, `ex_rd` is non-zero, `ex_rd` equals the tested register and `ex_load` is 0. During a stall, `next_pc` equals `fetch_pc`, `redirect` and `squash` are 0, and IF/ID keeps its contents.
- R9: When the matching EX producer has `ex_load` = 1, `stall_req` stays high for two consecutive cycles, even if EX holds a bubble in the second cycle.
- R10: No stall is requested when `ex_rd` is 0, or when the instruction in decode is a jump or call, whatever EX holds.
- R11: An empty decode slot (`id_wr_en` = 0) never redirects and never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| delay_mode | input | 1 | 1: one delay slot; 0: predict not taken, squash when redirected |
| fetch_instr | input | 32 | Instruction just fetched |
| fetch_pc | input | 32 | Address of `fetch_instr` |
| rs_val | input | 32 | Forwarded value of the register tested by the decode-slot instruction |
| ex_wr_en | input | 1 | Instruction in EX writes a register |
| ex_rd | input | 5 | Destination register of the EX instruction |
| ex_load | input | 1 | EX instruction is a load |
| id_instr | output | 32 | Instruction held in IF/ID |
| id_pc | output | 32 | Address of the instruction held in IF/ID |
| id_wr_en | output | 1 | IF/ID holds a live instruction (write enables allowed) |
| next_pc | output | 32 | Address to fetch at the next edge |
| redirect | output | 1 | `next_pc` is a branch or jump target |
| squash | output | 1 | IF/ID is replaced by a no-operation at the next edge |
| stall_req | output | 1 | Fetch and IF/ID hold for this cycle |

## Verification
A wrong zero test or target sum appears in the same cycle the branch sits in decode, as a wrong `next_pc` or `redirect`. A wrong squash decision appears one edge later, as a live `id_wr_en` where an empty slot was expected, or the reverse. A stall counter that is wrong in either direction shows within two cycles of the load match. It appears as a missing or extra `stall_req`, a `next_pc` that advances too early, or an IF/ID that changes while it should hold. The stimulus crosses both modes, both branch senses, negative offsets, a jump target whose upper address bits come from the incremented PC, and producers in EX with a zero and a non-zero destination.

// File: rtl/bru_pkg.sv
package bru_pkg;

    localparam int unsigned XLEN     = 32;
    localparam int unsigned REG_AW   = 5;
    localparam int unsigned OPC_W    = 6;
    localparam int unsigned IMM_W    = 16;
    localparam int unsigned JFLD_W   = 26;
    localparam int unsigned PC_STEP  = 4;
    localparam int unsigned PAGE_W   = XLEN - JFLD_W - 2;

    localparam logic [OPC_W-1:0] OPC_JUMP  = 6'h02;
    localparam logic [OPC_W-1:0] OPC_CALL  = 6'h03;
    localparam logic [OPC_W-1:0] OPC_BRZ   = 6'h04;
    localparam logic [OPC_W-1:0] OPC_BRNZ  = 6'h05;

    typedef logic [XLEN-1:0] word_t;

    typedef struct packed {
        logic  live;
        word_t instr;
        word_t pc;
    } slot_t;

    typedef struct packed {
        logic              is_cond;
        logic              is_jump;
        logic              on_zero;
        logic [REG_AW-1:0] src;
        word_t             target;
    } bdec_t;

    function automatic word_t sext_imm(input logic [IMM_W-1:0] imm);
        return {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    endfunction

    function automatic word_t seq_pc(input word_t pc);
        return pc + word_t'(PC_STEP);
    endfunction

    function automatic word_t jump_dest(input word_t pc, input logic [JFLD_W-1:0] fld);
        word_t nxt;
        nxt = seq_pc(pc);
        return {nxt[XLEN-1 -: PAGE_W], fld, 2'b00};
    endfunction

endpackage

// File: rtl/bru_ifid_reg.sv
module bru_ifid_reg
    import bru_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hold,
    input  logic  kill,
    input  word_t d_instr,
    input  word_t d_pc,
    output slot_t q
);

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            q <= '0;
        end else if (!hold) begin
            q <= '{live: 1'b1, instr: d_instr, pc: d_pc};
        end
    end

    // R7
    kill_empties_chk: assert property (@(posedge clk) disable iff (rst)
        kill |=> (!q.live && q.instr == '0));

    // R8
    hold_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (hold && !kill) |=> $stable(q));

endmodule

// File: rtl/bru_decode.sv
module bru_decode
    import bru_pkg::*;
(
    input  slot_t slot,
    output bdec_t dec
);

    logic [OPC_W-1:0] opc;
    word_t            br_tgt;
    word_t            jp_tgt;

    always_comb begin
        opc    = slot.instr[XLEN-1 -: OPC_W];
        br_tgt = slot.pc + sext_imm(slot.instr[IMM_W-1:0]);
        jp_tgt = jump_dest(slot.pc, slot.instr[JFLD_W-1:0]);

        dec.is_cond = slot.live && (opc == OPC_BRZ || opc == OPC_BRNZ);
        dec.is_jump = slot.live && (opc == OPC_JUMP || opc == OPC_CALL);
        dec.on_zero = (opc == OPC_BRZ);
        dec.src     = slot.instr[JFLD_W-1 -: REG_AW];
        dec.target  = dec.is_jump ? jp_tgt : br_tgt;
    end

endmodule

// File: rtl/bru_hazard.sv
module bru_hazard
    import bru_pkg::*;
#(
    parameter int unsigned LOAD_STALL = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              br_live,
    input  logic [REG_AW-1:0] br_src,
    input  logic              ex_wr_en,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_load,
    output logic              stall_o
);

    localparam int unsigned CW = (LOAD_STALL > 1) ? $clog2(LOAD_STALL) : 1;

    logic          ex_hit;
    logic          ld_hit;
    logic [CW-1:0] extra;

    always_comb begin
        ex_hit  = br_live && ex_wr_en && (ex_rd != '0) && (ex_rd == br_src);
        ld_hit  = ex_hit && ex_load && (extra == '0);
        stall_o = ex_hit || (extra != '0);
    end

    generate
        if (LOAD_STALL > 1) begin : g_ld_extra
            always_ff @(posedge clk) begin
                if (rst) begin
                    extra <= '0;
                end else if (ld_hit) begin
                    extra <= CW'(LOAD_STALL - 1);
                end else if (extra != '0) begin
                    extra <= extra - 1'b1;
                end
            end

            // R9
            load_second_stall_chk: assert property (@(posedge clk) disable iff (rst)
                ld_hit |=> stall_o);
        end else begin : g_no_extra
            always_comb extra = '0;
        end
    endgenerate

    // R10
    zero_dest_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (extra == '0 && ex_rd == '0) |-> !stall_o);

endmodule

// File: rtl/decode_redirect_unit.sv
module decode_redirect_unit
    import bru_pkg::*;
#(
    parameter int unsigned LOAD_STALL = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        delay_mode,
    input  logic [31:0] fetch_instr,
    input  logic [31:0] fetch_pc,
    input  logic [31:0] rs_val,
    input  logic        ex_wr_en,
    input  logic [4:0]  ex_rd,
    input  logic        ex_load,
    output logic [31:0] id_instr,
    output logic [31:0] id_pc,
    output logic        id_wr_en,
    output logic [31:0] next_pc,
    output logic        redirect,
    output logic        squash,
    output logic        stall_req
);

    slot_t slot;
    bdec_t dec;
    logic  hz_stall;
    logic  cond_met;

    bru_ifid_reg u_ifid (
        .clk     (clk),
        .rst     (rst),
        .hold    (hz_stall),
        .kill    (squash),
        .d_instr (fetch_instr),
        .d_pc    (fetch_pc),
        .q       (slot)
    );

    bru_decode u_dec (
        .slot (slot),
        .dec  (dec)
    );

    bru_hazard #(.LOAD_STALL(LOAD_STALL)) u_hz (
        .clk      (clk),
        .rst      (rst),
        .br_live  (dec.is_cond),
        .br_src   (dec.src),
        .ex_wr_en (ex_wr_en),
        .ex_rd    (ex_rd),
        .ex_load  (ex_load),
        .stall_o  (hz_stall)
    );

    always_comb begin
        cond_met  = dec.is_cond && (dec.on_zero == (rs_val == '0));
        stall_req = hz_stall;
        redirect  = !hz_stall && (dec.is_jump || cond_met);
        squash    = redirect && !delay_mode;
        if (hz_stall) begin
            next_pc = fetch_pc;
        end else if (redirect) begin
            next_pc = dec.target;
        end else begin
            next_pc = seq_pc(fetch_pc);
        end
        id_instr = slot.instr;
        id_pc    = slot.pc;
        id_wr_en = slot.live;
    end

    // R8
    stall_blocks_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        stall_req |-> (!redirect && !squash && next_pc == fetch_pc));

    // R6
    delay_no_squash_chk: assert property (@(posedge clk) disable iff (rst)
        (delay_mode && redirect) |=> id_wr_en);

    // R11
    empty_slot_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !id_wr_en |-> (!redirect && !stall_req));

    // R7
    squash_needs_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        squash |-> (redirect && !delay_mode));

endmodule

// File: tb/test_decode_redirect_unit.sv
module test_decode_redirect_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        delay_mode = 1'b0;
    logic [31:0] fetch_instr = '0;
    logic [31:0] fetch_pc = '0;
    logic [31:0] rs_val = '0;
    logic        ex_wr_en = 1'b0;
    logic [4:0]  ex_rd = '0;
    logic        ex_load = 1'b0;
    logic [31:0] id_instr, id_pc, next_pc;
    logic        id_wr_en, redirect, squash, stall_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    decode_redirect_unit i_decode_redirect_unit (
        .clk(clk), .rst(rst), .delay_mode(delay_mode),
        .fetch_instr(fetch_instr), .fetch_pc(fetch_pc), .rs_val(rs_val),
        .ex_wr_en(ex_wr_en), .ex_rd(ex_rd), .ex_load(ex_load),
        .id_instr(id_instr), .id_pc(id_pc), .id_wr_en(id_wr_en),
        .next_pc(next_pc), .redirect(redirect), .squash(squash),
        .stall_req(stall_req)
    );

    typedef struct {
        logic [31:0] npc;
        logic        rd, sq, st, v;
        logic [31:0] idi;
        string       req;
    } exp_t;

    exp_t sb[$];

    function automatic logic [31:0] brz(input logic [4:0] r, input logic [15:0] imm);
        return {6'h04, r, 5'd0, imm};
    endfunction
    function automatic logic [31:0] brnz(input logic [4:0] r, input logic [15:0] imm);
        return {6'h05, r, 5'd0, imm};
    endfunction
    function automatic logic [31:0] jmp(input logic [25:0] f);
        return {6'h02, f};
    endfunction
    function automatic logic [31:0] call(input logic [25:0] f);
        return {6'h03, f};
    endfunction

    localparam logic [31:0] A0 = 32'h0043_2020;
    localparam logic [31:0] A1 = 32'h0085_3020;
    localparam logic [31:0] A2 = 32'h00C6_4020;

    task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, expv, $time);
        end
    endtask

    task automatic step(input logic m, input logic [31:0] fi, input logic [31:0] fpc,
                        input logic [31:0] rv, input logic ew, input logic [4:0] erd,
                        input logic el, input logic [31:0] e_npc, input logic e_rd,
                        input logic e_sq, input logic e_st, input logic e_v,
                        input logic [31:0] e_id, input string req);
        exp_t e;
        @(negedge clk);
        rst = 1'b0;
        delay_mode = m; fetch_instr = fi; fetch_pc = fpc; rs_val = rv;
        ex_wr_en = ew; ex_rd = erd; ex_load = el;
        e.npc = e_npc; e.rd = e_rd; e.sq = e_sq; e.st = e_st; e.v = e_v;
        e.idi = e_id; e.req = req;
        sb.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            #4;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                cmp(e.req, "next_pc",   next_pc,           e.npc);
                cmp(e.req, "redirect",  {31'd0, redirect},  {31'd0, e.rd});
                cmp(e.req, "squash",    {31'd0, squash},    {31'd0, e.sq});
                cmp(e.req, "stall_req", {31'd0, stall_req}, {31'd0, e.st});
                cmp(e.req, "id_wr_en",  {31'd0, id_wr_en},  {31'd0, e.v});
                cmp(e.req, "id_instr",  id_instr,           e.idi);
            end
        end
    end

    initial begin : watchdog
        #2000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired, actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : driver
        repeat (2) @(negedge clk);
        // R1 post-reset slot empty; R2 sequential fetch
        step(0, brz(5'd3, 16'h0040), 32'h100, 0, 0, 0, 0, 32'h104, 0, 0, 0, 0, 32'h0, "R1 R2");
        // R3 R4 R7 taken on zero, squash in predict-not-taken mode
        step(0, A0, 32'h104, 0, 0, 0, 0, 32'h140, 1, 1, 0, 1, brz(5'd3, 16'h0040), "R3 R4 R7");
        step(0, A1, 32'h140, 0, 0, 0, 0, 32'h144, 0, 0, 0, 0, 32'h0, "R7 R11");
        step(0, brnz(5'd5, 16'hFFF0), 32'h144, 0, 0, 0, 0, 32'h148, 0, 0, 0, 1, A1, "R2");
        // R3 non-zero test fails on zero: no redirect, no squash
        step(0, A0, 32'h148, 0, 0, 0, 0, 32'h14C, 0, 0, 0, 1, brnz(5'd5, 16'hFFF0), "R3 R7");
        step(0, brnz(5'd5, 16'hFFF0), 32'h14C, 0, 0, 0, 0, 32'h150, 0, 0, 0, 1, A0, "R2");
        // R4 negative offset
        step(0, A2, 32'h150, 7, 0, 0, 0, 32'h13C, 1, 1, 0, 1, brnz(5'd5, 16'hFFF0), "R3 R4");
        step(0, jmp(26'h100), 32'h13C, 0, 0, 0, 0, 32'h140, 0, 0, 0, 0, 32'h0, "R7");
        step(0, A0, 32'h140, 0, 0, 0, 0, 32'h400, 1, 1, 0, 1, jmp(26'h100), "R5 R7");
        // delayed mode
        step(1, brz(5'd2, 16'h0020), 32'h400, 0, 0, 0, 0, 32'h404, 0, 0, 0, 0, 32'h0, "R11");
        step(1, A2, 32'h404, 0, 0, 0, 0, 32'h420, 1, 0, 0, 1, brz(5'd2, 16'h0020), "R6");
        step(1, A0, 32'h420, 0, 0, 0, 0, 32'h424, 0, 0, 0, 1, A2, "R6");
        step(1, call(26'h3FF_FFFF), 32'hAFFF_FFFC, 0, 0, 0, 0, 32'hB000_0000, 0, 0, 0, 1, A0, "R2");
        // R5 call, upper bits from incremented address
        step(1, A1, 32'hB000_0000, 0, 0, 0, 0, 32'hBFFF_FFFC, 1, 0, 0, 1, call(26'h3FF_FFFF), "R5 R6");
        step(0, brz(5'd4, 16'h0008), 32'hBFFF_FFFC, 0, 0, 0, 0, 32'hC000_0000, 0, 0, 0, 1, A1, "R6");
        // R8 ALU producer in EX: one stall
        step(0, A0, 32'hC000_0000, 0, 1, 5'd4, 0, 32'hC000_0000, 0, 0, 1, 1, brz(5'd4, 16'h0008), "R8");
        step(0, A0, 32'hC000_0000, 0, 0, 0, 0, 32'hC000_0004, 1, 1, 0, 1, brz(5'd4, 16'h0008), "R8 R4");
        step(0, brnz(5'd9, 16'h0010), 32'hC000_0004, 0, 0, 0, 0, 32'hC000_0008, 0, 0, 0, 0, 32'h0, "R7");
        // R9 load producer: two stalls
        step(0, A1, 32'hC000_0008, 3, 1, 5'd9, 1, 32'hC000_0008, 0, 0, 1, 1, brnz(5'd9, 16'h0010), "R9");
        step(0, A1, 32'hC000_0008, 3, 0, 0, 0, 32'hC000_0008, 0, 0, 1, 1, brnz(5'd9, 16'h0010), "R9");
        step(0, A1, 32'hC000_0008, 3, 0, 0, 0, 32'hC000_0014, 1, 1, 0, 1, brnz(5'd9, 16'h0010), "R9 R3");
        step(0, brz(5'd0, 16'h0010), 32'hC000_0014, 0, 0, 0, 0, 32'hC000_0018, 0, 0, 0, 0, 32'h0, "R7");
        // R10 destination zero: no stall
        step(0, A0, 32'hC000_0018, 0, 1, 5'd0, 1, 32'hC000_0024, 1, 1, 0, 1, brz(5'd0, 16'h0010), "R10");
        step(0, jmp(26'h0A0_0010), 32'hC000_0024, 0, 0, 0, 0, 32'hC000_0028, 0, 0, 0, 0, 32'h0, "R11");
        // R10 jump never stalls even with matching load in EX
        step(0, A0, 32'hC000_0028, 0, 1, 5'd5, 1, 32'hC280_0040, 1, 1, 0, 1, jmp(26'h0A0_0010), "R10 R5");
        step(0, A0, 32'hC280_0040, 0, 0, 0, 0, 32'hC280_0044, 0, 0, 0, 0, 32'h0, "R7 R11");
        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule